// File: doc/BRIEF.md
# Wake-on-LAN Power Mode Controller

This block decides when an Ethernet controller goes into its low-power wake-on-LAN mode and when it leaves it. It also turns a wake-frame detection into status and event outputs. There are two ways to arm the mode.

- **Software path.** Software sets a mode-select bit. The block then asks the controller to suspend and waits for the acknowledge, so that any network traffic already in progress can drain.
- **Hardware path.** A hardware arm bit, loaded at power-up or written later by software, arms the mode directly. No suspend handshake takes place.

Once the block is armed, a start event begins wake mode. A start event is either power-good falling or the software enable rising. A stop event ends wake mode: power-good rising or the software enable falling.

An external frame detector sends a one-cycle match strobe. A strobe that arrives during wake mode sets three sticky flags: match, interrupt cause and PME status. The match flag drives the remote-wake pin. The PME-status flag reaches the power-management event output only when one of its two enables is set. The interrupt-cause flag reaches the interrupt output only when both interrupt enables are set. Software clears each flag by writing 1 to its bit.

Top module: `wol_pm_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release until the first input change, `wake_active`, `susp_req` and all three flags are 0.
- R2: With `hw_arm` low, `mode_sel` high moves the block out of idle and raises `susp_req` one clock later. `susp_req` stays high until `susp_ack` is sampled high. No start event can begin wake mode before that point.
- R3: After the acknowledge, the block is armed and `susp_req` drops on the next clock. From the armed state, a start event raises `wake_active` on the next clock. A start event is a fall of `pwr_good` or a rise of `sw_en`, each measured against its value at the previous clock.
- R4: `hw_arm` high arms the block from idle on the next clock and never raises `susp_req`. A start event then raises `wake_active` on the next clock.
- R5: While `wake_active` is high, a stop event clears `wake_active` on the next clock and returns the block to idle. A stop event is a rise of `pwr_good` or a fall of `sw_en`. From idle the block must re-arm before it can enter wake mode again.
- R6: A `match_stb` sampled while `wake_active` is high sets `match_flag`, `cause_flag` and `pme_stat_flag` on the next clock.
- R7: A `match_stb` sampled while `wake_active` is low changes no flag.
- R8: `rwake_o` equals `match_flag` in every cycle.
- R9: `pme_o` is `pme_stat_flag` AND (`pme_en` OR `pme_en_ovr`), combinationally.
- R10: `irq_o` is `cause_flag` AND `int_en_glb` AND `int_en_wake`, combinationally.
- R11: The bits of `clr_flags` clear flags one clock later: bit 0 clears match, bit 1 clears cause, bit 2 clears PME status. A set from a match in the same cycle wins over a clear.
- R12: If `mode_sel` and `hw_arm` are both low while the block is waiting for the acknowledge or is armed, it returns to idle on the next clock, and `susp_req` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| mode_sel | input | 1 | Software wake-mode select |
| hw_arm | input | 1 | Hardware arm bit (power-up loaded or software written) |
| sw_en | input | 1 | Software enable; its rise starts and its fall stops wake mode |
| pwr_good | input | 1 | Power-good; its fall starts and its rise stops wake mode |
| susp_ack | input | 1 | Suspend acknowledge from the controller |
| susp_req | output | 1 | Suspend request to the controller |
| match_stb | input | 1 | One-cycle wake-frame match strobe |
| clr_flags | input | 3 | Write-one-to-clear: bit0 match, bit1 cause, bit2 PME status |
| pme_en | input | 1 | PME enable |
| pme_en_ovr | input | 1 | PME enable override |
| int_en_glb | input | 1 | Global interrupt enable |
| int_en_wake | input | 1 | Wake interrupt enable |
| wake_active | output | 1 | Wake mode indicator |
| match_flag | output | 1 | Sticky match flag |
| cause_flag | output | 1 | Sticky interrupt-cause flag |
| pme_stat_flag | output | 1 | Sticky PME status flag |
| rwake_o | output | 1 | Remote-wake pin |
| pme_o | output | 1 | Power-management event output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench raises `sw_en` before the suspend acknowledge arrives. A design that does not wait for the handshake would enter wake mode at that point. It also leaves `sw_en` high across an exit caused by `pwr_good`. A level-triggered design would then fall straight back into wake mode as soon as it re-armed.

The bench drives a match strobe and a full clear in the same cycle. A design with clear-over-set priority would lose that wake event. It also sends a strobe outside wake mode, which a design without that check would latch.

Finally, the bench tries each enable of the PME output and of the interrupt output on its own. An OR where an AND belongs, or the reverse, shows up as a wrong output level.

// File: rtl/wol_pkg.sv
package wol_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SUSP   = 2'd1,
    ST_ARMED  = 2'd2,
    ST_ACTIVE = 2'd3
  } wol_state_e;

  localparam int unsigned FLAG_W   = 3;
  localparam int unsigned FL_MATCH = 0;
  localparam int unsigned FL_CAUSE = 1;
  localparam int unsigned FL_PME   = 2;
endpackage

// File: rtl/wol_mode_fsm.sv
module wol_mode_fsm
  import wol_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic hw_arm,
  input  logic susp_ack,
  input  logic pwr_good,
  input  logic sw_en,
  output logic wake_active,
  output logic susp_req
);
  wol_state_e state_q, state_d;
  logic pg_q, en_q;
  logic arm_req, start_evt, stop_evt;

  always_comb begin
    arm_req   = mode_sel | hw_arm;
    start_evt = (pg_q & ~pwr_good) | (~en_q & sw_en);
    stop_evt  = (~pg_q & pwr_good) | (en_q & ~sw_en);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (hw_arm)        state_d = ST_ARMED;
        else if (mode_sel) state_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (!arm_req)              state_d = ST_IDLE;
        else if (hw_arm | susp_ack) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (!arm_req)       state_d = ST_IDLE;
        else if (start_evt) state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (stop_evt) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pg_q    <= 1'b1;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pg_q    <= pwr_good;
      en_q    <= sw_en;
    end
  end

  assign wake_active = (state_q == ST_ACTIVE);
  assign susp_req    = (state_q == ST_SUSP);

  p_no_entry_unsuspended_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP) |=> !wake_active);

  p_entry_from_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_active ##1 wake_active) |-> $past(state_q == ST_ARMED));

  p_hw_no_handshake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_arm && state_q == ST_IDLE) |=> !susp_req);

  p_exit_on_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_active && ((!pg_q && pwr_good) || (en_q && !sw_en))) |=> !wake_active);

  p_withdraw_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_req && !mode_sel && !hw_arm) |=> !susp_req);
endmodule

// File: rtl/wol_flags.sv
module wol_flags
  import wol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              match_stb,
  input  logic [FLAG_W-1:0] clr_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic hit;
  assign hit = active_i & match_stb;

  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
    logic f_q, f_d, f_en;

    always_comb begin
      f_en = hit | clr_i[k];
      f_d  = hit | (f_q & ~clr_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    f_q <= 1'b0;
      else if (f_en) f_q <= f_d;
    end

    assign flags_o[k] = f_q;

    p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !hit) |=> !flags_o[k]);
  end

  p_match_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && match_stb) |=> (&flags_o));

  p_idle_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && clr_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/wol_out_gate.sv
module wol_out_gate
  import wol_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              pme_en,
  input  logic              pme_en_ovr,
  input  logic              int_en_glb,
  input  logic              int_en_wake,
  output logic              rwake_o,
  output logic              pme_o,
  output logic              irq_o
);
  always_comb begin
    rwake_o = flags_i[FL_MATCH];
    pme_o   = flags_i[FL_PME] & (pme_en | pme_en_ovr);
    irq_o   = flags_i[FL_CAUSE] & int_en_glb & int_en_wake;
  end
endmodule

// File: rtl/wol_pm_ctrl.sv
module wol_pm_ctrl
  import wol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              hw_arm,
  input  logic              sw_en,
  input  logic              pwr_good,
  input  logic              susp_ack,
  output logic              susp_req,
  input  logic              match_stb,
  input  logic [FLAG_W-1:0] clr_flags,
  input  logic              pme_en,
  input  logic              pme_en_ovr,
  input  logic              int_en_glb,
  input  logic              int_en_wake,
  output logic              wake_active,
  output logic              match_flag,
  output logic              cause_flag,
  output logic              pme_stat_flag,
  output logic              rwake_o,
  output logic              pme_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] flags;

  wol_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .hw_arm(hw_arm),
    .susp_ack(susp_ack), .pwr_good(pwr_good), .sw_en(sw_en),
    .wake_active(wake_active), .susp_req(susp_req)
  );

  wol_flags u_flags (
    .clk(clk), .rst_n(rst_n), .active_i(wake_active),
    .match_stb(match_stb), .clr_i(clr_flags), .flags_o(flags)
  );

  wol_out_gate u_gate (
    .flags_i(flags), .pme_en(pme_en), .pme_en_ovr(pme_en_ovr),
    .int_en_glb(int_en_glb), .int_en_wake(int_en_wake),
    .rwake_o(rwake_o), .pme_o(pme_o), .irq_o(irq_o)
  );

  assign match_flag    = flags[FL_MATCH];
  assign cause_flag    = flags[FL_CAUSE];
  assign pme_stat_flag = flags[FL_PME];

  p_rwake_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_stb && wake_active) |=> rwake_o);
endmodule

// File: tb/tb_wol_pm_ctrl.sv
`timescale 1ns/1ps
module tb_wol_pm_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic mode_sel, hw_arm, sw_en, pwr_good, susp_ack, match_stb;
  logic [2:0] clr_flags;
  logic pme_en, pme_en_ovr, int_en_glb, int_en_wake;
  logic susp_req, wake_active, match_flag, cause_flag, pme_stat_flag;
  logic rwake_o, pme_o, irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wol_pm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .hw_arm(hw_arm),
    .sw_en(sw_en), .pwr_good(pwr_good), .susp_ack(susp_ack),
    .susp_req(susp_req), .match_stb(match_stb), .clr_flags(clr_flags),
    .pme_en(pme_en), .pme_en_ovr(pme_en_ovr), .int_en_glb(int_en_glb),
    .int_en_wake(int_en_wake), .wake_active(wake_active),
    .match_flag(match_flag), .cause_flag(cause_flag),
    .pme_stat_flag(pme_stat_flag), .rwake_o(rwake_o), .pme_o(pme_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 idle, 1 waiting for ack, 2 armed, 3 in wake mode
  int m_mode;
  bit m_pg_prev, m_en_prev;
  bit m_match, m_cause, m_pme;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pg_prev = 1; m_en_prev = 0;
      m_match = 0; m_cause = 0; m_pme = 0;
    end else begin
      bit in_wake, go, stop, keep;
      in_wake = (m_mode == 3);
      go   = (m_pg_prev && !pwr_good) || (!m_en_prev && sw_en);
      stop = (!m_pg_prev && pwr_good) || (m_en_prev && !sw_en);
      keep = mode_sel || hw_arm;
      m_match = (in_wake && match_stb) || (m_match && !clr_flags[0]);
      m_cause = (in_wake && match_stb) || (m_cause && !clr_flags[1]);
      m_pme   = (in_wake && match_stb) || (m_pme   && !clr_flags[2]);
      if (m_mode == 0)      m_mode = hw_arm ? 2 : (mode_sel ? 1 : 0);
      else if (m_mode == 1) m_mode = !keep ? 0 : ((hw_arm || susp_ack) ? 2 : 1);
      else if (m_mode == 2) m_mode = !keep ? 0 : (go ? 3 : 2);
      else                  m_mode = stop ? 0 : 3;
      m_pg_prev = pwr_good;
      m_en_prev = sw_en;
    end
    #1;
    chk("R3 model wake_active", wake_active, m_mode == 3);
    chk("R2 model susp_req", susp_req, m_mode == 1);
    chk("R6 model match_flag", match_flag, m_match);
    chk("R6 model cause_flag", cause_flag, m_cause);
    chk("R6 model pme_stat_flag", pme_stat_flag, m_pme);
    chk("R8 model rwake_o", rwake_o, m_match);
    chk("R9 model pme_o", pme_o, m_pme && (pme_en || pme_en_ovr));
    chk("R10 model irq_o", irq_o, m_cause && int_en_glb && int_en_wake);
  end

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_sel = 0; hw_arm = 0; sw_en = 0; pwr_good = 1;
    susp_ack = 0; match_stb = 0; clr_flags = 3'b000;
    pme_en = 0; pme_en_ovr = 0; int_en_glb = 0; int_en_wake = 0;
    repeat (3) step();
    chk("R1 reset wake_active", wake_active, 1'b0);
    chk("R1 reset susp_req", susp_req, 1'b0);
    chk("R1 reset flags", match_flag | cause_flag | pme_stat_flag, 1'b0);
    rst_n = 1;
    step();
    chk("R1 after release", wake_active | susp_req, 1'b0);

    // software path
    mode_sel = 1;
    step();
    chk("R2 susp_req raised", susp_req, 1'b1);
    sw_en = 1;
    step();
    chk("R2 no entry before ack", wake_active, 1'b0);
    chk("R2 susp_req held", susp_req, 1'b1);
    sw_en = 0;
    step();
    susp_ack = 1;
    step();
    chk("R3 susp_req dropped", susp_req, 1'b0);
    susp_ack = 0; sw_en = 1;
    step();
    chk("R3 enter on sw_en rise", wake_active, 1'b1);
    match_stb = 1;
    step();
    match_stb = 0;
    chk("R6 match flag", match_flag, 1'b1);
    chk("R6 cause flag", cause_flag, 1'b1);
    chk("R6 pme status", pme_stat_flag, 1'b1);
    chk("R8 rwake on", rwake_o, 1'b1);
    chk("R9 pme gated off", pme_o, 1'b0);
    chk("R10 irq gated off", irq_o, 1'b0);
    pme_en = 1; int_en_glb = 1; #1;
    chk("R9 pme via enable", pme_o, 1'b1);
    chk("R10 irq needs both", irq_o, 1'b0);
    int_en_wake = 1; #1;
    chk("R10 irq both set", irq_o, 1'b1);
    step();
    clr_flags = 3'b001;
    step();
    clr_flags = 3'b000;
    chk("R11 match cleared", match_flag, 1'b0);
    chk("R8 rwake off", rwake_o, 1'b0);
    chk("R11 cause kept", cause_flag, 1'b1);
    chk("R11 pme kept", pme_stat_flag, 1'b1);
    match_stb = 1; clr_flags = 3'b111;
    step();
    match_stb = 0; clr_flags = 3'b000;
    chk("R11 set wins match", match_flag, 1'b1);
    chk("R11 set wins pme", pme_stat_flag, 1'b1);
    sw_en = 0;
    step();
    chk("R5 exit on sw_en fall", wake_active, 1'b0);
    clr_flags = 3'b111;
    step();
    clr_flags = 3'b000; match_stb = 1;
    step();
    match_stb = 0;
    chk("R7 ignored match", match_flag | cause_flag | pme_stat_flag, 1'b0);
    chk("R2 re-handshake", susp_req, 1'b1);
    mode_sel = 0;
    step();
    chk("R12 withdraw drops req", susp_req, 1'b0);

    // hardware path; sw_en held high across the exit
    hw_arm = 1; sw_en = 1;
    step();
    chk("R4 no susp_req", susp_req, 1'b0);
    chk("R4 armed not active", wake_active, 1'b0);
    pwr_good = 0;
    step();
    chk("R4 enter on pg fall", wake_active, 1'b1);
    pwr_good = 1;
    step();
    chk("R5 exit on pg rise", wake_active, 1'b0);
    step();
    chk("R5 no level re-entry", wake_active, 1'b0);
    pwr_good = 0;
    step();
    chk("R4 re-entry on new event", wake_active, 1'b1);
    pme_en = 0; pme_en_ovr = 1; match_stb = 1;
    step();
    match_stb = 0;
    chk("R9 pme via override", pme_o, 1'b1);
    int_en_glb = 0; #1;
    chk("R10 irq global off", irq_o, 1'b0);
    repeat (3) step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule